// File: doc/BRIEF.md
# Audio Sample FIFO with Watermark Fetch and Sticky Interrupt Status

This block sits between a memory fetch engine and an audio link inserter. It buffers audio sample words in eight 64-byte slots (128 words of 32 bits). When the fill level drops below a software-chosen watermark, it raises a fetch request. The request stays up until the fetch engine has delivered one complete 64-byte burst. The inserter pulls one word per request and receives the word one cycle later.

When the inserter asks for a word while the buffer is empty, the block answers anyway. It returns either a zero (silence) sample or a null-packet flag, according to a configuration bit. It also latches an underrun flag. A second sticky flag, buffer-done, is raised each time a programmed number of bytes has been written into the buffer. Both flags are cleared by writing 1, and each has its own interrupt enable. The interrupt line is the OR of every flag gated by its enable.

The fetch side is one two-state machine. In state FETCH_IDLE, the transition "request" moves it to FETCH_BURST. This happens when the level is below the watermark and at least one burst of space is free. In FETCH_BURST, the transition "final beat" returns it to FETCH_IDLE once the sixteenth word has been accepted.

Top module: `audio_fifo_irq`

## Requirements
- R1: Words leave in the order they were written. A word demanded with `smp_req` in one cycle appears on `smp_data` with `smp_valid`=1 in the next cycle. The buffer holds 128 words, and a level of 112 words is reachable.
- R2: Config register (address 0) bits 10:8 hold a watermark W, in units of 16 words. The block enters FETCH_BURST only when the level is below 16·W and at least 16 words are free. W=0 never requests.
- R3: `fetch_req` stays high until 16 words have been accepted. A word is accepted when `fetch_req` and `fetch_valid` are both 1. After the sixteenth word, `fetch_req` is low for at least one cycle.
- R4: A demand while the buffer is empty sets status register (address 1) bit 31 (underrun).
- R5: If config bit 11 is 1, a starved demand returns `smp_valid`=1, `smp_null`=0 and zero data. If bit 11 is 0, it returns `smp_valid`=1, `smp_null`=1 and zero data.
- R6: Writing 1 to status bit 31 or bit 29 clears that bit. Writing 0 leaves it unchanged.
- R7: The length register (address 2, bits 15:0) holds a byte count L, and each accepted word counts 4 bytes. When the running count reaches L, status bit 29 (buffer-done) is set and the count restarts from zero. L=0 never sets it. Writing the length register restarts the count.
- R8: Status bit 15 enables the underrun interrupt and bit 13 enables the buffer-done interrupt. Writing the status register loads both enables, whatever the clear bits are. `irq` = (bit31 AND bit15) OR (bit29 AND bit13).
- R9: When a flag's set event and a write-1 clear of that flag fall in the same cycle, the flag ends up set.
- R10: After reset, all registers read 0, and `fetch_req`, `smp_valid`, `smp_null` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_req | output | 1 | Burst request to the fetch engine |
| fetch_valid | input | 1 | Fetch engine presents a word |
| fetch_data | input | 32 | Word from the fetch engine |
| smp_req | input | 1 | Inserter demands one word |
| smp_valid | output | 1 | Answer to last cycle's demand |
| smp_null | output | 1 | Answer is a null packet |
| smp_data | output | 32 | Sample word (zero when starved) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 config, 1 status, 2 length |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle, because a sticky flag's set event and a software clear of that flag are independent. The first pair is an empty-buffer demand and a status write that clears bit 31, driven on the same clock edge. The second pair is the final accepted word that completes the byte count and a status write that clears bit 29, presented on the same beat. In both cases the bench reads the status register afterwards and expects the flag still set. It also checks that the interrupt line follows that flag.

// File: rtl/afi_pkg.sv
package afi_pkg;
    typedef enum logic [0:0] {
        FETCH_IDLE  = 1'b0,
        FETCH_BURST = 1'b1
    } fetch_state_e;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_LEN  = 2'd2;

    localparam int CFG_WM_LSB   = 8;
    localparam int CFG_WM_W     = 3;
    localparam int CFG_SIL_BIT  = 11;
    localparam int ST_UND_BIT   = 31;
    localparam int ST_DONE_BIT  = 29;
    localparam int ST_UND_EN    = 15;
    localparam int ST_DONE_EN   = 13;
endpackage

// File: rtl/afi_store.sv
module afi_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 128,
    parameter int LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] pop_data,
    output logic [LVL_W-1:0]  level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] DEPTH_L  = LVL_W'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [LVL_W-1:0]  count;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign pop_data = mem[rd_ptr];
    assign level    = count;

    // R1: a push never lands on a full buffer
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < DEPTH_L));
    // R1: a pop never drains an empty buffer
    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/afi_fetch.sv
module afi_fetch
    import afi_pkg::*;
#(
    parameter int BEATS = 16,
    parameter int DEPTH = 128,
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [2:0]       wm,
    input  logic             wr_valid,
    output logic             fetch_req,
    output logic             accept
);
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [LVL_W-1:0]  DEPTH_L   = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0]  BEATS_L   = LVL_W'(BEATS);
    localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BEATS - 1);

    fetch_state_e      state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic [LVL_W-1:0]  thresh, free_words;
    logic              below_mark, room, last_beat;

    always_comb begin
        thresh     = LVL_W'(wm) * BEATS_L;
        free_words = DEPTH_L - level;
        below_mark = level < thresh;
        room       = free_words >= BEATS_L;
        last_beat  = beat_q == BEAT_LAST;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FETCH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: "request" and "final beat"
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FETCH_IDLE:  if (below_mark && room)   state_d = FETCH_BURST;
            FETCH_BURST: if (accept && last_beat)  state_d = FETCH_IDLE;
            default:                               state_d = FETCH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fetch_req = (state_q == FETCH_BURST);
        accept    = fetch_req && wr_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (state_q == FETCH_IDLE) begin
            beat_q <= '0;
        end else if (accept) begin
            beat_q <= last_beat ? '0 : beat_q + 1'b1;
        end
    end

    // R2: a burst only starts when there was room for all of it
    assert_req_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> $past(room));
    // R2: space left always covers the rest of the burst
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (free_words >= (BEATS_L - LVL_W'(beat_q))));
    // R3: request only drops after the final beat was taken
    assert_burst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fetch_req) |-> $past(accept && last_beat));
endmodule

// File: rtl/afi_regs.sv
module afi_regs
    import afi_pkg::*;
#(
    parameter int BYTES_PER_WORD = 4,
    parameter int LEN_W          = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        underrun_evt,
    input  logic        accept,
    output logic [2:0]  wm,
    output logic        silence,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    logic [LEN_W-1:0] len_q, byte_q;
    logic [LEN_W:0]   next_bytes;
    logic             und_q, done_q, en_und_q, en_done_q;
    logic             wr_cfg, wr_stat, wr_len, done_evt;

    always_comb begin
        wr_cfg     = reg_wr && (reg_addr == ADDR_CFG);
        wr_stat    = reg_wr && (reg_addr == ADDR_STAT);
        wr_len     = reg_wr && (reg_addr == ADDR_LEN);
        next_bytes = {1'b0, byte_q} + (LEN_W+1)'(BYTES_PER_WORD);
        done_evt   = accept && (len_q != '0) && (next_bytes >= {1'b0, len_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wm      <= '0;
            silence <= 1'b0;
            len_q   <= '0;
        end else begin
            if (wr_cfg) begin
                wm      <= reg_wdata[CFG_WM_LSB +: CFG_WM_W];
                silence <= reg_wdata[CFG_SIL_BIT];
            end
            if (wr_len) begin
                len_q <= reg_wdata[LEN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (wr_len) begin
            byte_q <= '0;
        end else if (accept) begin
            byte_q <= done_evt ? '0 : next_bytes[LEN_W-1:0];
        end
    end

    // sticky flags: the set event outranks a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            und_q     <= 1'b0;
            done_q    <= 1'b0;
            en_und_q  <= 1'b0;
            en_done_q <= 1'b0;
        end else begin
            und_q  <= underrun_evt | (und_q  & ~(wr_stat & reg_wdata[ST_UND_BIT]));
            done_q <= done_evt     | (done_q & ~(wr_stat & reg_wdata[ST_DONE_BIT]));
            if (wr_stat) begin
                en_und_q  <= reg_wdata[ST_UND_EN];
                en_done_q <= reg_wdata[ST_DONE_EN];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CFG: begin
                reg_rdata[CFG_WM_LSB +: CFG_WM_W] = wm;
                reg_rdata[CFG_SIL_BIT]            = silence;
            end
            ADDR_STAT: begin
                reg_rdata[ST_UND_BIT]  = und_q;
                reg_rdata[ST_DONE_BIT] = done_q;
                reg_rdata[ST_UND_EN]   = en_und_q;
                reg_rdata[ST_DONE_EN]  = en_done_q;
            end
            ADDR_LEN: reg_rdata[LEN_W-1:0] = len_q;
            default:  reg_rdata = '0;
        endcase
        irq = (und_q & en_und_q) | (done_q & en_done_q);
    end

    // R9: a set event always leaves its flag high
    assert_underrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_evt |=> und_q);
    assert_done_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> done_q);
    // R6: a status write with a zero in bit 31 leaves the underrun flag alone
    assert_zero_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !reg_wdata[ST_UND_BIT] && !underrun_evt) |=> (und_q == $past(und_q)));
    // R8: no interrupt without a pending flag
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (und_q || done_q));
    // R7: byte count never runs past a nonzero length
    assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q != '0 && !$past(wr_len)) |-> (byte_q < len_q) || (byte_q == '0));
endmodule

// File: rtl/audio_fifo_irq.sv
module audio_fifo_irq #(
    parameter int WORD_W      = 32,
    parameter int BURST_BYTES = 64,
    parameter int SLOTS       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fetch_req,
    input  logic              fetch_valid,
    input  logic [WORD_W-1:0] fetch_data,
    input  logic              smp_req,
    output logic              smp_valid,
    output logic              smp_null,
    output logic [WORD_W-1:0] smp_data,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int BEATS          = BURST_BYTES / BYTES_PER_WORD;
    localparam int DEPTH          = BEATS * SLOTS;
    localparam int LVL_W          = $clog2(DEPTH) + 1;

    logic [LVL_W-1:0]  level;
    logic [WORD_W-1:0] pop_data;
    logic [2:0]        wm;
    logic              silence, accept, pop, starve;

    always_comb begin
        pop    = smp_req && (level != '0);
        starve = smp_req && (level == '0);
    end

    afi_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .push_data(fetch_data),
        .pop(pop), .pop_data(pop_data),
        .level(level)
    );

    afi_fetch #(.BEATS(BEATS), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .level(level), .wm(wm), .wr_valid(fetch_valid),
        .fetch_req(fetch_req), .accept(accept)
    );

    afi_regs #(.BYTES_PER_WORD(BYTES_PER_WORD), .LEN_W(16)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .underrun_evt(starve), .accept(accept),
        .wm(wm), .silence(silence),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_null  <= 1'b0;
            smp_data  <= '0;
        end else begin
            smp_valid <= smp_req;
            smp_null  <= starve && !silence;
            smp_data  <= pop ? pop_data : '0;
        end
    end

    // R5: a null-packet answer never carries sample data
    assert_starve_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_null |-> (smp_valid && smp_data == '0));
    // R1: every demand is answered in the following cycle
    assert_answer_R1: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |=> smp_valid);
endmodule

// File: tb/tb_audio_fifo_irq.sv
module tb_audio_fifo_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req, fetch_valid = 1'b0;
    logic [31:0] fetch_data = '0;
    logic        smp_req = 1'b0, smp_valid, smp_null;
    logic [31:0] smp_data;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model_q[$];

    always #10 clk = ~clk;

    audio_fifo_irq dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .smp_req(smp_req), .smp_valid(smp_valid), .smp_null(smp_null), .smp_data(smp_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // one full burst; optionally clears buffer-done on the final beat
    task automatic burst(input logic [31:0] base, input bit clear_last);
        bit held = 1'b1;
        for (int k = 0; k < 20 && !fetch_req; k++) @(negedge clk);
        check("R2 request raised", {31'b0, fetch_req}, 32'd1);
        if (!fetch_req) return;
        for (int i = 0; i < 16; i++) begin
            if (!fetch_req) held = 1'b0;
            fetch_valid = 1'b1;
            fetch_data  = base + i;
            if (clear_last && i == 15) begin
                reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h2000_2000;
            end
            model_q.push_back(base + i);
            @(negedge clk);
        end
        fetch_valid = 1'b0;
        reg_wr      = 1'b0;
        check("R3 request held for 16 beats", {31'b0, held}, 32'd1);
        check("R3 request drops after last beat", {31'b0, fetch_req}, 32'd0);
    endtask

    task automatic pull(input logic exp_null);
        logic [31:0] exp;
        bit empty;
        empty = (model_q.size() == 0);
        exp = empty ? 32'h0 : model_q.pop_front();
        @(negedge clk);
        smp_req = 1'b1;
        @(negedge clk);
        smp_req = 1'b0;
        if (smp_valid !== 1'b1 || smp_data !== exp || smp_null !== (empty & exp_null)) begin
            check(empty ? "R5 starved answer" : "R1 sample order",
                  {smp_valid, smp_null, 30'b0} ^ smp_data, {1'b1, empty & exp_null, 30'b0} ^ exp);
        end else begin
            n_chk++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R10 fetch_req", {31'b0, fetch_req}, 32'd0);
        check("R10 irq", {31'b0, irq}, 32'd0);
        check("R10 smp_valid", {31'b0, smp_valid}, 32'd0);
        reg_read(2'd0, v); check("R10 config", v, 32'h0);
        reg_read(2'd1, v); check("R10 status", v, 32'h0);
        reg_read(2'd2, v); check("R10 length", v, 32'h0);
    endtask

    task automatic t_fill_and_drain();
        repeat (4) @(negedge clk);
        check("R2 watermark 0 never requests", {31'b0, fetch_req}, 32'd0);
        reg_write(2'd0, 32'h0000_0200);
        burst(32'h1000, 1'b0);
        burst(32'h2000, 1'b0);
        repeat (3) @(negedge clk);
        check("R2 no request at level 32 with mark 2", {31'b0, fetch_req}, 32'd0);
        reg_write(2'd0, 32'h0);
        for (int i = 0; i < 32; i++) pull(1'b1);
    endtask

    task automatic t_underrun_null();
        logic [31:0] v;
        pull(1'b1);
        reg_read(2'd1, v); check("R4 underrun flag", v, 32'h8000_0000);
        check("R8 irq masked", {31'b0, irq}, 32'd0);
        reg_write(2'd1, 32'h0000_8000);
        reg_read(2'd1, v); check("R6 zero write keeps flag", v, 32'h8000_8000);
        check("R8 irq enabled", {31'b0, irq}, 32'd1);
        reg_write(2'd1, 32'h8000_8000);
        reg_read(2'd1, v); check("R6 write-one clears", v, 32'h0000_8000);
        check("R8 irq cleared", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_silence_and_collide();
        logic [31:0] v;
        reg_write(2'd0, 32'h0000_0800);
        pull(1'b0);
        reg_read(2'd1, v); check("R5 silence also flags underrun", v, 32'h8000_8000);
        reg_write(2'd1, 32'h8000_8000);
        @(negedge clk);
        smp_req = 1'b1;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h8000_8000;
        @(negedge clk);
        smp_req = 1'b0; reg_wr = 1'b0;
        check("R5 silence answer", {30'b0, smp_valid, smp_null}, 32'd2);
        reg_read(2'd1, v); check("R9 underrun set beats clear", v, 32'h8000_8000);
        check("R9 irq after collision", {31'b0, irq}, 32'd1);
        reg_write(2'd1, 32'h8000_0000);
    endtask

    task automatic t_done();
        logic [31:0] v;
        reg_write(2'd1, 32'h0000_2000);
        reg_write(2'd2, 32'd128);
        reg_write(2'd0, 32'h0000_0A00);
        burst(32'h3000, 1'b0);
        reg_read(2'd1, v); check("R7 done not yet at 64 of 128 bytes", v, 32'h0000_2000);
        burst(32'h3100, 1'b0);
        reg_read(2'd1, v); check("R7 done at 128 bytes", v, 32'h2000_2000);
        check("R8 done irq", {31'b0, irq}, 32'd1);
        reg_write(2'd1, 32'h2000_2000);
        reg_read(2'd1, v); check("R6 done cleared", v, 32'h0000_2000);
        reg_write(2'd2, 32'd64);
        reg_write(2'd0, 32'h0000_0B00);
        burst(32'h3200, 1'b1);
        reg_read(2'd1, v); check("R9 done set beats clear", v, 32'h2000_2000);
        reg_write(2'd2, 32'd0);
        reg_write(2'd1, 32'h2000_0000);
    endtask

    task automatic t_deep();
        logic [31:0] v;
        reg_write(2'd0, 32'h0000_0F00);
        for (int b = 0; b < 4; b++) burst(32'h4000 + 32'h100 * b, 1'b0);
        repeat (3) @(negedge clk);
        check("R2 fill stops at 112 words", {31'b0, fetch_req}, 32'd0);
        reg_read(2'd1, v); check("R7 length 0 never sets done", v, 32'h0);
        reg_write(2'd0, 32'h0);
        check("R1 model holds 112", model_q.size(), 32'd112);
        for (int i = 0; i < 112; i++) pull(1'b1);
        pull(1'b1);
        reg_read(2'd1, v); check("R4 underrun after deep drain", v, 32'h8000_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_drain();
        t_underrun_null();
        t_silence_and_collide();
        t_done();
        t_deep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule